// File: doc/BRIEF.md
# Binary Phase Detector Clock and Data Recovery Loop

This block recovers a bit clock from a serial stream that arrives already oversampled, eight samples per bit, one sample per system clock. A 16-bit phase accumulator stands in for the oscillator. Its top bit is the recovered bit clock. The top bit rising marks the retiming instant, and the accumulator wrapping is the edge that the loop lines up with the data transitions.

On every rising data transition, a two-state phase detector records whether the transition arrived while the recovered clock was still high or after it had fallen. The block has no dead zone. The decision is held until the next rising transition.

The accumulator increment is the sum of two terms:

- A slow integral word that learns the incoming bit rate, clamped between two limits.
- A proportional term that is either zero or one full step, depending on the held decision.

Because the loop acts only on transition events, and each event has the same weight, the loop gain does not depend on how sparse the transitions are.

Top module: `bb_cdr`

## Requirements
- R1: While reset is held, `rdata`, `bclk_stb` and `early` are 0, `integ` equals INT_INIT (default 8160), and both limit flags are low.
- R2: A rising data transition (sample 0 followed by sample 1) seen while the accumulator top bit is 1 sets `early` to 1. This is the window from a strobe until the next wrap. A rising transition seen while the top bit is 0 clears `early`. `early` has only these two values.
- R3: `early` changes only in the cycle after a rising data transition. Falling transitions and steady data leave it unchanged.
- R4: Each cycle the accumulator advances by `integ + prop_step` when `early` is 1 and by `integ` alone when it is 0. `bclk_stb` pulses for one cycle each time the top bit goes from 0 to 1, so the strobe spacing follows the two increment levels.
- R5: At each strobe, `rdata` holds the input sample taken in the clock cycle in which the top bit rose.
- R6: On each rising data transition, `integ` moves up by `int_step` when the new decision is 1 and down by `int_step` when it is 0, clamped to [INT_MIN, INT_MAX] (defaults 7168 and 9216). At all other times it holds its value.
- R7: `int_at_max` is high exactly when `integ` equals INT_MAX, and `int_at_min` is high exactly when `integ` equals INT_MIN.
- R8: The input is a pseudo-random bit stream whose bit period is 2000 ppm longer than eight samples. After settling, the loop strobes each transmitted bit exactly once with no slip, `rdata` equals that bit, and the sampling instant lies between 0.2 and 0.8 of the bit.
- R9: The same offset stream is sent as runs of 20 equal bits, which gives 0.05 transitions per bit. After settling, each bit is strobed exactly once with the correct value, and the sampling instant lies between 0.05 and 0.95 of the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one input sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Oversampled serial data |
| prop_step | input | 16 | Proportional step added when the decision is 1 |
| int_step | input | 16 | Integral change per rising data transition |
| rdata | output | 1 | Retimed data |
| bclk_stb | output | 1 | One-cycle pulse per recovered bit |
| early | output | 1 | Held phase decision |
| integ | output | 16 | Integral (frequency) word |
| int_at_min | output | 1 | Integral word at its lower limit |
| int_at_max | output | 1 | Integral word at its upper limit |

## Verification
Single data pulses timed against the strobe place a rising transition deliberately in the high half or the low half of the recovered clock. This separates the two detector decisions. The strobe spacing that follows, with the integral path frozen, shows whether the proportional term really switches between exactly two increments. Repeating the same timed pulses with the proportional step at zero drives the integral word into each of its limits. A dense pseudo-random stream and a run-length stream, both with the same rate offset, show whether tracking and bit alignment survive when transitions become ten times rarer.

// File: rtl/bb_cdr.sv
`timescale 1ns/1ps
module bb_cdr #(
  parameter int PW       = 16,
  parameter int OSR      = 8,
  parameter int NOM_INC  = (1 << PW) / OSR,
  parameter int INT_INIT = NOM_INC - 32,
  parameter int INT_MIN  = NOM_INC - NOM_INC / 8,
  parameter int INT_MAX  = NOM_INC + NOM_INC / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [PW-1:0] prop_step,
  input  logic [PW-1:0] int_step,
  output logic          rdata,
  output logic          bclk_stb,
  output logic          early,
  output logic [PW-1:0] integ,
  output logic          int_at_min,
  output logic          int_at_max
);
  localparam int TOP = PW - 1;
  localparam logic [PW-1:0] LO   = PW'(INT_MIN);
  localparam logic [PW-1:0] HI   = PW'(INT_MAX);
  localparam logic [PW-1:0] INIT = PW'(INT_INIT);

  logic          din_q;
  logic [PW-1:0] phase;
  logic [PW-1:0] inc;
  logic [PW-1:0] phase_nxt;
  logic [PW-1:0] integ_nxt;
  logic [PW:0]   up_sum;
  logic          din_rise;
  logic          pd_now;
  logic          clk_up;

  assign din_rise  = din & ~din_q;
  assign pd_now    = phase[TOP];
  assign inc       = integ + (early ? prop_step : '0);
  assign phase_nxt = phase + inc;
  assign clk_up    = ~phase[TOP] & phase_nxt[TOP];
  assign up_sum    = {1'b0, integ} + {1'b0, int_step};

  always_comb begin
    if (pd_now)
      integ_nxt = (up_sum > {1'b0, HI}) ? HI : up_sum[PW-1:0];
    else if (int_step > integ || (integ - int_step) < LO)
      integ_nxt = LO;
    else
      integ_nxt = integ - int_step;
  end

  assign int_at_min = (integ == LO);
  assign int_at_max = (integ == HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q    <= 1'b0;
      phase    <= '0;
      bclk_stb <= 1'b0;
      rdata    <= 1'b0;
      early    <= 1'b0;
      integ    <= INIT;
    end else begin
      din_q    <= din;
      phase    <= phase_nxt;
      bclk_stb <= clk_up;
      if (clk_up) rdata <= din;
      if (din_rise) begin
        early <= pd_now;
        integ <= integ_nxt;
      end
    end
  end

  // R3
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(early) |-> $past(din_rise));

  // R6
  integ_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (integ != $past(integ)) |-> $past(din_rise));

  // R6
  integ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (integ >= LO) && (integ <= HI));

  // R4
  stb_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_stb |-> phase[TOP]);

  // R5
  retime_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_stb |-> (rdata == $past(din)));
endmodule

// File: tb/bb_cdr_bench.sv
`timescale 1ns/1ps
module bb_cdr_bench;
  localparam int IMIN  = 7168;
  localparam int IMAX  = 9216;
  localparam int IINIT = 8160;
  localparam longint ONE = 64'd16777216;
  localparam longint TX_INC = 64'd2092966;

  logic clk = 0;
  logic rst_n = 0;
  logic din = 0;
  logic [15:0] prop_step = 0;
  logic [15:0] int_step = 0;
  logic rdata, bclk_stb, early, int_at_min, int_at_max;
  logic [15:0] integ;

  int total = 0;
  int bad = 0;

  bb_cdr u_bb_cdr (
    .clk(clk), .rst_n(rst_n), .din(din), .prop_step(prop_step), .int_step(int_step),
    .rdata(rdata), .bclk_stb(bclk_stb), .early(early), .integ(integ),
    .int_at_min(int_at_min), .int_at_max(int_at_max));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // background invariants for R3, R6, R7
  bit mon_din_prev, mon_early_prev, mon_rise;
  int mon_integ_prev, mon_exp;
  int bad3 = 0, bad6 = 0, bad7 = 0;
  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      mon_din_prev   = 0;
      mon_early_prev = early;
      mon_integ_prev = int'(integ);
    end else begin
      mon_rise = din && !mon_din_prev;
      if (early != mon_early_prev && !mon_rise) bad3++;
      mon_exp = mon_integ_prev;
      if (mon_rise) begin
        if (early) mon_exp = mon_integ_prev + int'(int_step);
        else       mon_exp = mon_integ_prev - int'(int_step);
        if (mon_exp > IMAX) mon_exp = IMAX;
        if (mon_exp < IMIN) mon_exp = IMIN;
      end
      if (int'(integ) != mon_exp) bad6++;
      if (int_at_max != (int'(integ) == IMAX)) bad7++;
      if (int_at_min != (int'(integ) == IMIN)) bad7++;
      mon_din_prev   = din;
      mon_early_prev = early;
      mon_integ_prev = int'(integ);
    end
  end

  task automatic do_reset(input int p, input int s);
    @(negedge clk);
    rst_n = 0; din = 0;
    prop_step = 16'(p); int_step = 16'(s);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_stb();
    do begin @(posedge clk); #2; end while (!bclk_stb);
  endtask

  task automatic measure(input int lo, input int hi, input int n, input string tag);
    int errs = 0;
    int worst = 0;
    wait_stb();
    for (int i = 0; i < n; i++) begin
      int cnt = 0;
      do begin @(posedge clk); #2; cnt++; end while (!bclk_stb);
      if (cnt < lo || cnt > hi) begin errs++; worst = cnt; end
    end
    chk(errs == 0, tag, worst, lo);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 0; din = 1;
    repeat (3) @(posedge clk);
    #2;
    chk(rdata == 0, "R1 rdata", int'(rdata), 0);
    chk(bclk_stb == 0, "R1 bclk_stb", int'(bclk_stb), 0);
    chk(early == 0, "R1 early", int'(early), 0);
    chk(int'(integ) == IINIT, "R1 integ", int'(integ), IINIT);
    chk(!int_at_min && !int_at_max, "R1 flags", int'({int_at_max, int_at_min}), 0);
  endtask

  task automatic t_prop();
    do_reset(4096, 0);
    wait_stb();
    @(negedge clk); din = 1;
    @(negedge clk); din = 0;
    @(posedge clk); #2;
    chk(early == 1, "R2 high half gives early=1", int'(early), 1);
    measure(5, 6, 12, "R4 spacing with step added");
    chk(early == 1, "R3 decision held over idle data", int'(early), 1);
    wait_stb();
    repeat (4) @(negedge clk);
    din = 1;
    @(negedge clk); din = 0;
    @(posedge clk); #2;
    chk(early == 0, "R2 low half gives early=0", int'(early), 0);
    measure(8, 9, 12, "R4 spacing without step");
    chk(int'(integ) == IINIT, "R6 zero step keeps integ", int'(integ), IINIT);
  endtask

  task automatic t_sat_max();
    do_reset(0, 64);
    for (int i = 0; i < 24; i++) begin
      wait_stb();
      @(negedge clk); din = 1;
      @(negedge clk); din = 0;
    end
    @(posedge clk); #2;
    chk(int'(integ) == IMAX, "R6 clamp at upper limit", int'(integ), IMAX);
    chk(int_at_max == 1, "R7 upper flag", int'(int_at_max), 1);
    chk(early == 1, "R2 repeated high-half pulses", int'(early), 1);
  endtask

  task automatic t_sat_min();
    do_reset(0, 64);
    for (int i = 0; i < 24; i++) begin
      wait_stb();
      repeat (6) @(negedge clk);
      din = 1;
      @(negedge clk); din = 0;
    end
    @(posedge clk); #2;
    chk(int'(integ) == IMIN, "R6 clamp at lower limit", int'(integ), IMIN);
    chk(int_at_min == 1, "R7 lower flag", int'(int_at_min), 1);
    chk(early == 0, "R2 repeated low-half pulses", int'(early), 0);
  endtask

  task automatic t_track(input bit sparse, input int settle, input int meas,
                         input real lo, input real hi, input string tag);
    longint frac = 0;
    int bidx = 0;
    bit cur = 0;
    bit [6:0] lfsr = 7'h5b;
    int drv_idx = 0;
    bit drv_bit = 0;
    longint drv_frac = 0;
    int last_idx = 0;
    bit have_last = 0;
    int n = 0, bad_d = 0, bad_s = 0, bad_p = 0;
    real fr;
    do_reset(64, 1);
    while (bidx < settle + meas) begin
      @(negedge clk);
      frac += TX_INC;
      if (frac >= ONE) begin
        frac -= ONE;
        bidx++;
        if (sparse) cur = ((bidx / 20) % 2) == 1;
        else begin
          lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
          cur = lfsr[0];
        end
      end
      din = cur;
      drv_idx = bidx; drv_bit = cur; drv_frac = frac;
      @(posedge clk); #2;
      if (bclk_stb && bidx > settle) begin
        n++;
        if (rdata != drv_bit) bad_d++;
        if (have_last && drv_idx != last_idx + 1) bad_s++;
        fr = real'(drv_frac) / real'(ONE);
        if (fr < lo || fr > hi) bad_p++;
        last_idx = drv_idx;
        have_last = 1;
      end
    end
    chk(n > (meas * 9) / 10, {tag, " strobe count"}, n, meas);
    chk(bad_d == 0, {tag, " R5 retimed value"}, bad_d, 0);
    chk(bad_s == 0, {tag, " bit slips"}, bad_s, 0);
    chk(bad_p == 0, {tag, " sampling point"}, bad_p, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_prop();
    t_sat_max();
    t_sat_min();
    t_track(0, 1500, 1500, 0.2, 0.8, "R8 dense");
    t_track(1, 3000, 2000, 0.05, 0.95, "R9 sparse");
    chk(bad3 == 0, "R3 decision moved without rising edge", bad3, 0);
    chk(bad6 == 0, "R6 integral update rule", bad6, 0);
    chk(bad7 == 0, "R7 limit flags", bad7, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule